// File: doc/BRIEF.md
# Protected Flash Command Decoder

This block sits on the write path of a word-wide flash controller and turns a stream of bus write cycles into flash commands. Each write cycle carries an address and a 16-bit data word. The block accepts a command only after a fixed unlock handshake. When a sequence finishes, the block emits a single-cycle command pulse. The pulse carries a code, the latched target address and the latched data, and the array engine downstream uses them to run the operation.

Five operations are recognised: word program, sector erase, block erase, whole-array erase, and entry to or exit from an identification mode. While identification mode is active, a small read port returns the manufacturer and device codes. A busy input from the array engine freezes the decoder, so writes that arrive while an operation runs cannot start, advance or abort a sequence. Any write that breaks the expected order sends the decoder back to idle and is dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and just after a synchronous active-low reset, `cmd_valid`, `id_mode` and `rd_valid` are 0.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a fourth write (A, D), raise `cmd_valid` in the cycle after that fourth write. The code is 1, `cmd_addr`=A and `cmd_data`=D.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by 30h at any address A, issue code 2. `cmd_addr` is A with bits 10..0 cleared and `cmd_data` is 0.
- R4: The same five-write prefix followed by 50h at address A issues code 3. `cmd_addr` is A with bits 14..0 cleared and `cmd_data` is 0.
- R5: The same five-write prefix followed by 10h@5555h issues code 4, with `cmd_addr`=0 and `cmd_data`=0.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h issues code 5 and sets `id_mode` in the same cycle as the pulse.
- R7: While `id_mode`=1, a read at word 0 returns 00BFh and a read at word 1 returns 2782h. Any other word returns 0000h. `rd_valid` and `rd_data` come one cycle after `rd_en`. With `id_mode`=0, `rd_valid` stays 0.
- R8: A single F0h write to any address from idle issues code 6 and clears `id_mode`. So does AAh@5555h, 55h@2AAAh, F0h@5555h.
- R9: Only address bits 14..0 and data bits 7..0 are compared during command steps.
- R10: A write that does not match the expected step returns the decoder to idle without issuing anything, and that write does not start a new sequence.
- R11: A write made while `busy`=1 has no effect. The sequence position and `id_mode` are held, and no command is issued for it.
- R12: `cmd_valid` is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | 20 | Write word address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Array operation in progress; writes ignored |
| rd_en | input | 1 | Identification read strobe |
| rd_addr | input | 20 | Identification read word address |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 array erase, 5 ID enter, 6 ID exit |
| cmd_addr | output | 20 | Latched target address |
| cmd_data | output | 16 | Latched program data |
| id_mode | output | 1 | Identification mode active |
| rd_valid | output | 1 | Identification read data valid |
| rd_data | output | 16 | Identification read data |

## Verification
Every result is one register away from its stimulus. A completing write shows up on `cmd_valid`, `cmd_code`, `cmd_addr`, `cmd_data` and `id_mode` after the next rising edge. An identification read shows up on `rd_valid` and `rd_data` after the same single edge. The bench drives each write or read on a falling edge and holds it across one rising edge. It then samples the outputs on the following falling edge, so every table row is checked exactly one cycle after its own write. Rows that do not complete a sequence expect `cmd_valid` low at that point, and this covers aborts, busy writes and the one-cycle pulse width.

// File: rtl/flash_cmd_pkg.sv
// Shared types and key values for the protected flash command decoder.
// Assumes the unlock keys compare 15 address bits and 8 data bits.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE         = 3'd0,
        CMD_PROGRAM      = 3'd1,
        CMD_SECTOR_ERASE = 3'd2,
        CMD_BLOCK_ERASE  = 3'd3,
        CMD_CHIP_ERASE   = 3'd4,
        CMD_ID_ENTER     = 3'd5,
        CMD_ID_EXIT      = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS3,
        ST_ERS4,
        ST_ERS5
    } step_e;

    localparam int KEY_ADDR_W = 15;
    localparam int KEY_DATA_W = 8;

    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;

    // Data code table; index constants below name each entry.
    localparam int N_CODES = 9;
    localparam logic [KEY_DATA_W-1:0] DATA_CODES [N_CODES] = '{
        8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'hF0, 8'h30, 8'h50, 8'h10
    };
    localparam int IX_AA = 0;
    localparam int IX_55 = 1;
    localparam int IX_A0 = 2;
    localparam int IX_80 = 3;
    localparam int IX_90 = 4;
    localparam int IX_F0 = 5;
    localparam int IX_30 = 6;
    localparam int IX_50 = 7;
    localparam int IX_10 = 8;

endpackage

// File: rtl/fcd_key_match.sv
// Key comparator: flags whether the compared address bits equal either
// unlock address and which known data code the compared data bits carry.
// Purely combinational; assumes the caller passes only the compared bits.
module fcd_key_match
    import flash_cmd_pkg::*;
(
    input  logic [KEY_ADDR_W-1:0] key_addr,
    input  logic [KEY_DATA_W-1:0] key_data,
    output logic                  is_addr_a,
    output logic                  is_addr_b,
    output logic [N_CODES-1:0]    data_hit
);

    // Address key compare.
    assign is_addr_a = (key_addr == KEY_ADDR_A);
    assign is_addr_b = (key_addr == KEY_ADDR_B);

    // One comparator per data code in the package table.
    for (genvar i = 0; i < N_CODES; i++) begin : g_code
        assign data_hit[i] = (key_data == DATA_CODES[i]);
    end

endmodule

// File: rtl/fcd_sequencer.sv
// Command sequencer: steps through the unlock and command writes, issues a
// one-cycle command with latched address/data, and tracks ID mode.
// Assumes busy-time writes must leave all state untouched.
module fcd_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int SECTOR_LSB = 11,
    parameter int BLOCK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              is_addr_a,
    input  logic              is_addr_b,
    input  logic [N_CODES-1:0] data_hit,
    output logic              cmd_valid,
    output cmd_e              cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              id_mode
);

    localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;
    localparam logic [DATA_W-1:0] ZERO_DATA = '0;

    step_e             st_q, st_d;
    logic              id_q, id_d;
    logic              issue;
    cmd_e              code_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] data_d;
    logic              take;

    logic [ADDR_W-1:0] sector_addr;
    logic [ADDR_W-1:0] block_addr;

    assign take        = wr_en && !busy;
    assign sector_addr = {wr_addr[ADDR_W-1:SECTOR_LSB], {SECTOR_LSB{1'b0}}};
    assign block_addr  = {wr_addr[ADDR_W-1:BLOCK_LSB],  {BLOCK_LSB{1'b0}}};

    // Next step, command to issue and ID-mode update for the current write.
    always_comb begin
        st_d   = st_q;
        id_d   = id_q;
        issue  = 1'b0;
        code_d = CMD_NONE;
        addr_d = ZERO_ADDR;
        data_d = ZERO_DATA;
        if (take) begin
            st_d = ST_IDLE;
            case (st_q)
                ST_IDLE: begin
                    if (is_addr_a && data_hit[IX_AA]) begin
                        st_d = ST_UNL1;
                    end else if (data_hit[IX_F0]) begin
                        issue  = 1'b1;
                        code_d = CMD_ID_EXIT;
                        id_d   = 1'b0;
                    end
                end
                ST_UNL1: begin
                    if (is_addr_b && data_hit[IX_55]) st_d = ST_UNL2;
                end
                ST_UNL2: begin
                    if (is_addr_a) begin
                        if (data_hit[IX_A0]) begin
                            st_d = ST_PROG;
                        end else if (data_hit[IX_80]) begin
                            st_d = ST_ERS3;
                        end else if (data_hit[IX_90]) begin
                            issue  = 1'b1;
                            code_d = CMD_ID_ENTER;
                            id_d   = 1'b1;
                        end else if (data_hit[IX_F0]) begin
                            issue  = 1'b1;
                            code_d = CMD_ID_EXIT;
                            id_d   = 1'b0;
                        end
                    end
                end
                ST_PROG: begin
                    issue  = 1'b1;
                    code_d = CMD_PROGRAM;
                    addr_d = wr_addr;
                    data_d = wr_data;
                end
                ST_ERS3: begin
                    if (is_addr_a && data_hit[IX_AA]) st_d = ST_ERS4;
                end
                ST_ERS4: begin
                    if (is_addr_b && data_hit[IX_55]) st_d = ST_ERS5;
                end
                ST_ERS5: begin
                    if (data_hit[IX_30]) begin
                        issue  = 1'b1;
                        code_d = CMD_SECTOR_ERASE;
                        addr_d = sector_addr;
                    end else if (data_hit[IX_50]) begin
                        issue  = 1'b1;
                        code_d = CMD_BLOCK_ERASE;
                        addr_d = block_addr;
                    end else if (is_addr_a && data_hit[IX_10]) begin
                        issue  = 1'b1;
                        code_d = CMD_CHIP_ERASE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Sequence position and ID mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            id_q <= 1'b0;
        end else begin
            st_q <= st_d;
            id_q <= id_d;
        end
    end

    // Command pulse and fields; fields hold their last issued value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= CMD_NONE;
            cmd_addr  <= ZERO_ADDR;
            cmd_data  <= ZERO_DATA;
        end else begin
            cmd_valid <= issue;
            if (issue) begin
                cmd_code <= code_d;
                cmd_addr <= addr_d;
                cmd_data <= data_d;
            end
        end
    end

    assign id_mode = id_q;

endmodule

// File: rtl/fcd_id_port.sv
// Identification read port: returns manufacturer code at word 0, device
// code at word 1, zero elsewhere, one cycle after the read strobe.
// Assumes reads outside ID mode are served elsewhere and are not flagged.
module fcd_id_port #(
    parameter int          ADDR_W = 20,
    parameter int          DATA_W = 16,
    parameter logic [15:0] MFR_ID = 16'h00BF,
    parameter logic [15:0] DEV_ID = 16'h2782
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_mode,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] WORD0 = '0;
    localparam logic [ADDR_W-1:0] WORD1 = ADDR_W'(1);

    logic [DATA_W-1:0] sel_data;

    // Pick the code for the requested word.
    always_comb begin
        if (rd_addr == WORD0)      sel_data = DATA_W'(MFR_ID);
        else if (rd_addr == WORD1) sel_data = DATA_W'(DEV_ID);
        else                       sel_data = '0;
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en && id_mode;
            if (rd_en && id_mode) rd_data <= sel_data;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the protected flash command decoder: key comparator, command
// sequencer and identification read port. Assumes one write per cycle.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          DATA_W     = 16,
    parameter int          SECTOR_LSB = 11,
    parameter int          BLOCK_LSB  = 15,
    parameter logic [15:0] MFR_ID     = 16'h00BF,
    parameter logic [15:0] DEV_ID     = 16'h2782
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              id_mode,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic               is_addr_a;
    logic               is_addr_b;
    logic [N_CODES-1:0] data_hit;
    cmd_e               code_q;

    fcd_key_match u_match (
        .key_addr  (wr_addr[KEY_ADDR_W-1:0]),
        .key_data  (wr_data[KEY_DATA_W-1:0]),
        .is_addr_a (is_addr_a),
        .is_addr_b (is_addr_b),
        .data_hit  (data_hit)
    );

    fcd_sequencer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SECTOR_LSB (SECTOR_LSB),
        .BLOCK_LSB  (BLOCK_LSB)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .busy      (busy),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .is_addr_a (is_addr_a),
        .is_addr_b (is_addr_b),
        .data_hit  (data_hit),
        .cmd_valid (cmd_valid),
        .cmd_code  (code_q),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .id_mode   (id_mode)
    );

    assign cmd_code = code_q;

    fcd_id_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_id (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_mode  (id_mode),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/fcd_checker.sv
// Property checker for the command decoder, attached by bind below.
// Assumes the command codes listed in the brief.
module fcd_checker #(
    parameter int ADDR_W     = 20,
    parameter int SECTOR_LSB = 11,
    parameter int BLOCK_LSB  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic              rd_en,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              id_mode,
    input logic              rd_valid
);

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_busy_no_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> !cmd_valid);

    p_busy_id_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(id_mode));

    p_no_write_id_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(id_mode));

    p_sector_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd2) |-> (cmd_addr[SECTOR_LSB-1:0] == '0));

    p_block_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd3) |-> (cmd_addr[BLOCK_LSB-1:0] == '0));

    p_chip_addr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd4) |-> (cmd_addr == '0));

    p_enter_sets_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd5) |-> id_mode);

    p_exit_clears_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd6) |-> !id_mode);

    p_code_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code != 3'd0 && cmd_code != 3'd7));

    p_read_needs_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && id_mode));

endmodule

bind flash_cmd_decoder fcd_checker #(
    .ADDR_W     (ADDR_W),
    .SECTOR_LSB (SECTOR_LSB),
    .BLOCK_LSB  (BLOCK_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .rd_en     (rd_en),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr),
    .id_mode   (id_mode),
    .rd_valid  (rd_valid)
);

// File: tb/flash_cmd_decoder_tb.sv
// Self-checking bench: a table of write cycles with expected results,
// then directed tests for reset, ID reads and pulse width.
module flash_cmd_decoder_tb;

    typedef struct packed {
        logic        busy;
        logic [19:0] addr;
        logic [15:0] data;
        logic        ev;
        logic [2:0]  ec;
        logic [19:0] ea;
        logic [15:0] ed;
        logic        eid;
    } vec_t;

    localparam int NV = 55;
    localparam vec_t VEC [NV] = '{
        // R2 program
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h31234, 16'hBEEF, 1'b1, 3'd1, 20'h31234, 16'hBEEF, 1'b0},
        // R3 sector erase
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h45A37, 16'h0030, 1'b1, 3'd2, 20'h45800, 16'h0, 1'b0},
        // R4 block erase
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'hCABCD, 16'h0050, 1'b1, 3'd3, 20'hC8000, 16'h0, 1'b0},
        // R5 whole-array erase
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h0010, 1'b1, 3'd4, 20'h0, 16'h0, 1'b0},
        // R9 upper address and data bits ignored
        '{1'b0, 20'h85555, 16'h12AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'hF2AAA, 16'hFF55, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h1D555, 16'h77A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h00010, 16'h1234, 1'b1, 3'd1, 20'h00010, 16'h1234, 1'b0},
        // R10 wrong address at step 2 aborts
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h01234, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h00020, 16'h5678, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        // R10 wrong data at step 3 aborts
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h0077, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        // R11 busy write inside a sequence holds position
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b1, 20'h05555, 16'h00A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h00030, 16'hCAFE, 1'b1, 3'd1, 20'h00030, 16'hCAFE, 1'b0},
        // R11 whole sequence while busy is dropped
        '{1'b1, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b1, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b1, 20'h05555, 16'h00A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b1, 20'h00040, 16'h1111, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        // R6 ID entry
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h0090, 1'b1, 3'd5, 20'h0, 16'h0, 1'b1},
        // R11 F0 while busy does not leave ID mode
        '{1'b1, 20'h00000, 16'h00F0, 1'b0, 3'd0, 20'h0, 16'h0, 1'b1},
        // R8 single-write exit
        '{1'b0, 20'h01234, 16'h00F0, 1'b1, 3'd6, 20'h0, 16'h0, 1'b0},
        // R6 enter again
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0},
        '{1'b0, 20'h05555, 16'h0090, 1'b1, 3'd5, 20'h0, 16'h0, 1'b1},
        // R8 three-write exit
        '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 20'h0, 16'h0, 1'b1},
        '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 20'h0, 16'h0, 1'b1},
        '{1'b0, 20'h05555, 16'h00F0, 1'b1, 3'd6, 20'h0, 16'h0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        rd_en = 1'b0;
    logic [19:0] rd_addr = '0;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [19:0] cmd_addr;
    logic [15:0] cmd_data;
    logic        id_mode;
    logic        rd_valid;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .id_mode   (id_mode),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one write on a falling edge; returns on the next falling edge.
    task automatic do_write(input logic b, input logic [19:0] a, input logic [15:0] d);
        wr_en = 1'b1; busy = b; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; busy = 1'b0;
    endtask

    task automatic do_read(input logic [19:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] act, exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cmd_valid == 1'b0 && id_mode == 1'b0 && rd_valid == 1'b0, "R1 reset outputs",
              {cmd_valid, id_mode, rd_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_valid == 1'b0 && id_mode == 1'b0, "R1 after release", {cmd_valid, id_mode}, 2'b00);

        // Table walk: each row checked one cycle after its write.
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i].busy, VEC[i].addr, VEC[i].data);
            if (VEC[i].ev) begin
                act = {cmd_valid, cmd_code, cmd_addr, cmd_data, id_mode};
                exp = {1'b1, VEC[i].ec, VEC[i].ea, VEC[i].ed, VEC[i].eid};
            end else begin
                act = {cmd_valid, id_mode};
                exp = {1'b0, VEC[i].eid};
            end
            check(act == exp, $sformatf("R2-table row %0d (R2 R3 R4 R5 R6 R8 R9 R10 R11)", i), act, exp);
        end

        // R12: pulse lasts one cycle.
        do_write(1'b0, 20'h05555, 16'h00AA);
        do_write(1'b0, 20'h02AAA, 16'h0055);
        do_write(1'b0, 20'h05555, 16'h00A0);
        do_write(1'b0, 20'h00777, 16'h0F0F);
        check(cmd_valid == 1'b1 && cmd_code == 3'd1, "R12 pulse high", {cmd_valid, cmd_code}, {1'b1, 3'd1});
        @(negedge clk);
        check(cmd_valid == 1'b0, "R12 pulse low next cycle", cmd_valid, 1'b0);

        // R7: reads outside ID mode are not flagged.
        do_read(20'h00000);
        check(rd_valid == 1'b0, "R7 no read outside ID", rd_valid, 1'b0);

        // R7: ID reads.
        do_write(1'b0, 20'h05555, 16'h00AA);
        do_write(1'b0, 20'h02AAA, 16'h0055);
        do_write(1'b0, 20'h05555, 16'h0090);
        check(id_mode == 1'b1, "R6 ID entered", id_mode, 1'b1);
        do_read(20'h00000);
        check(rd_valid && rd_data == 16'h00BF, "R7 word0", {rd_valid, rd_data}, {1'b1, 16'h00BF});
        do_read(20'h00001);
        check(rd_valid && rd_data == 16'h2782, "R7 word1", {rd_valid, rd_data}, {1'b1, 16'h2782});
        do_read(20'h00005);
        check(rd_valid && rd_data == 16'h0000, "R7 other word", {rd_valid, rd_data}, {1'b1, 16'h0000});
        @(negedge clk);
        check(rd_valid == 1'b0, "R7 valid drops", rd_valid, 1'b0);

        // R1: reset while in ID mode clears it.
        rst_n = 1'b0;
        @(negedge clk);
        check(id_mode == 1'b0 && cmd_valid == 1'b0, "R1 reset leaves ID", {id_mode, cmd_valid}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(20'h00001);
        check(rd_valid == 1'b0, "R7 no read after reset", rd_valid, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule